// File: doc/BRIEF.md
# Serial Bit-Pattern Trigger

This block watches a one-bit serial stream that is sampled on every rising clock edge. It keeps the most recent eight samples in a sliding window. It raises a registered trigger whenever the window value belongs to a programmable set of accepted patterns. The accepted set is a table with one bit per possible window value, so any mix of patterns can be armed at once. A bit set at index N means that window value N fires the trigger.

A small write port lets the table be changed while the block runs, one entry per clock, without stopping the stream. A synchronous clear empties the window. Matching uses no framing: any eight consecutive samples can fire, wherever they fall relative to byte boundaries. The design has no state machine. Its state is the window register, the table and the registered trigger.

Top module: `serial_pattern_trigger`

## Requirements
- R1: On each clock edge with `win_clr` low and `rst_n` high, the window shifts one place toward its MSB and `ser_in` enters at bit 0.
- R2: When `win_clr` is high on a clock edge, the window becomes all zeros and the value on `ser_in` is dropped.
- R3: `trig` is registered. After a clock edge, it equals the table entry indexed by the window value held just before that edge. A bit sampled at edge k therefore first influences `trig` after edge k+1.
- R4: The accepted set may hold several patterns at once. For example, with entries 0xF0 and 0xF1 both set, either window value fires `trig`.
- R5: Matching uses a sliding window. With only entry 0xFF set, the stream 00000111 followed by 11111000 (MSB first) fires `trig` once eight consecutive ones have entered.
- R6: While `rst_n` is low, `trig` goes low, the window clears and every table entry clears. After reset, no window value fires until entries are written.
- R7: A write with `tbl_we` high stores `tbl_bit` at index `tbl_addr` on that edge. The new entry is first used by the comparison made on the following edge.
- R8: During and after a clear, a zero window is treated like any other value. `trig` follows table entry 0 with no suppression.
- R9: `trig` stays high on every consecutive cycle in which the window matches. For example, a long run of ones against entry 0xFF holds it high continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low; clears window, table and trigger |
| win_clr | input | 1 | Synchronous window clear, active high |
| ser_in | input | 1 | Serial data bit sampled each clock |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 8 | Table index (window value) to write |
| tbl_bit | input | 1 | Value written to the table entry |
| trig | output | 1 | Registered trigger, high when the previous window value is accepted |

## Verification
Some properties are checked on every clock by assertions. These are: the shift step and the clear of the window, the one-cycle relation between the table lookup and `trig`, the store of each table write, and the reset value of `trig`.

Other behaviours need concrete streams, so only the bench scenarios can show them. These are: several patterns armed at once, matches that straddle byte boundaries, a trigger held high across a run of ones, entry 0 governing the output during a clear, and a write becoming visible exactly one comparison later. The bench sweeps every window value under an arithmetically generated table and a pseudo-random stream, and compares `trig` on each cycle against its own model.

// File: rtl/spt_pkg.sv
package spt_pkg;
    // Default window width; the table holds one bit per window value.
    localparam int DEF_WIN_W = 8;
endpackage

// File: rtl/spt_window.sv
module spt_window #(
    parameter int WIN_W = spt_pkg::DEF_WIN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bit_in,
    output logic [WIN_W-1:0] win
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            win <= '0;
        end else begin
            win <= {win[WIN_W-2:0], bit_in};
        end
    end

    // R1: new sample lands at bit 0, older samples move toward the MSB
    a_r1_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (win[0] == $past(bit_in)) && (win[WIN_W-1:1] == $past(win[WIN_W-2:0])));

    // R2: clear empties the window whatever the serial input was
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (win == '0));
endmodule

// File: rtl/spt_match_table.sv
module spt_match_table #(
    parameter int WIN_W = spt_pkg::DEF_WIN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIN_W-1:0] addr,
    input  logic             wbit,
    input  logic [WIN_W-1:0] key,
    output logic             hit
);
    localparam int DEPTH = 1 << WIN_W;

    logic [DEPTH-1:0] accept;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept <= '0;
        end else if (we) begin
            accept[addr] <= wbit;
        end
    end

    assign hit = accept[key];

    // R7: an accepted write is held in the addressed entry on the next cycle
    a_r7_write_stored: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (accept[$past(addr)] == $past(wbit)));
endmodule

// File: rtl/serial_pattern_trigger.sv
module serial_pattern_trigger #(
    parameter int WIN_W = spt_pkg::DEF_WIN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_clr,
    input  logic             ser_in,
    input  logic             tbl_we,
    input  logic [WIN_W-1:0] tbl_addr,
    input  logic             tbl_bit,
    output logic             trig
);
    logic [WIN_W-1:0] window;
    logic             lookup_hit;

    spt_window #(.WIN_W(WIN_W)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (win_clr),
        .bit_in (ser_in),
        .win    (window)
    );

    spt_match_table #(.WIN_W(WIN_W)) u_table (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (tbl_we),
        .addr (tbl_addr),
        .wbit (tbl_bit),
        .key  (window),
        .hit  (lookup_hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig <= 1'b0;
        end else begin
            trig <= lookup_hit;
        end
    end

    // R3: trigger follows the lookup of the previous window with one cycle of delay
    a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (trig == $past(lookup_hit)));

    // R6: reset forces the trigger low
    a_r6_reset_low: assert property (@(posedge clk)
        !rst_n |=> (trig == 1'b0));
endmodule

// File: tb/tb_serial_pattern_trigger.sv
module tb_serial_pattern_trigger;
    localparam int W = 8;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         win_clr = 1'b0;
    logic         ser_in = 1'b0;
    logic         tbl_we = 1'b0;
    logic [W-1:0] tbl_addr = '0;
    logic         tbl_bit = 1'b0;
    logic         trig;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [W-1:0] m_win = '0;
    logic [N-1:0] m_tbl = '0;
    logic         m_trig = 1'b0;

    always #10 clk = ~clk;

    serial_pattern_trigger #(.WIN_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .win_clr(win_clr), .ser_in(ser_in),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_bit(tbl_bit), .trig(trig)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: trig=%0b expected %0b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, update the model at posedge, compare just after.
    task automatic step(input logic b, input logic c, input logic we,
                        input logic [W-1:0] a, input logic d, input string tag);
        logic nt;
        ser_in = b; win_clr = c; tbl_we = we; tbl_addr = a; tbl_bit = d;
        @(posedge clk);
        nt = m_tbl[m_win];
        if (c) m_win = '0; else m_win = {m_win[W-2:0], b};
        if (we) m_tbl[a] = d;
        m_trig = nt;
        #1;
        check(trig, m_trig, tag);
        @(negedge clk);
    endtask

    task automatic feed_byte(input logic [7:0] v, input string tag);
        for (int i = 7; i >= 0; i--) step(v[i], 1'b0, 1'b0, '0, 1'b0, tag);
    endtask

    task automatic wr(input logic [W-1:0] a, input logic d, input string tag);
        step(1'b0, 1'b1, 1'b1, a, d, tag);
    endtask

    task automatic wipe(input string tag);
        for (int i = 0; i < N; i++) wr(i[W-1:0], 1'b0, tag);
    endtask

    initial begin
        logic [15:0] lfsr;
        // R6: reset state
        repeat (3) @(negedge clk);
        #1 check(trig, 1'b0, "R6 reset trig low");
        rst_n = 1'b1;
        // R6: empty table after reset, sweep every window value
        for (int v = 0; v < N; v++) feed_byte(v[7:0], "R6 empty table");

        // R1/R3: single pattern 0xA5 fires with one-cycle latency
        wr(8'hA5, 1'b1, "R3 program");
        feed_byte(8'hA5, "R1 shift into window");
        step(1'b0, 1'b0, 1'b0, '0, 1'b0, "R3 latency fire");
        check(trig, 1'b1, "R3 fires one cycle after completing bit");
        step(1'b0, 1'b0, 1'b0, '0, 1'b0, "R3 drop");
        check(trig, 1'b0, "R3 low after window moves on");
        wr(8'hA5, 1'b0, "R3 unprogram");

        // R4: two patterns armed together
        wr(8'hF0, 1'b1, "R4 program");
        wr(8'hF1, 1'b1, "R4 program");
        feed_byte(8'hF0, "R4 first pattern");
        step(1'b1, 1'b0, 1'b0, '0, 1'b0, "R4 first fires");
        check(trig, 1'b1, "R4 0xF0 fires");
        feed_byte(8'hF1, "R4 second pattern");
        step(1'b0, 1'b0, 1'b0, '0, 1'b0, "R4 second fires");
        check(trig, 1'b1, "R4 0xF1 fires");
        wr(8'hF0, 1'b0, "R4 clear");
        wr(8'hF1, 1'b0, "R4 clear");

        // R5: unaligned match across byte boundary
        wr(8'hFF, 1'b1, "R5 program");
        feed_byte(8'h07, "R5 first byte");
        feed_byte(8'hF8, "R5 second byte");
        // eight ones complete after the 5th bit of byte two; trig seen one step later
        // R9: long run of ones keeps trig high
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 1'b0, 1'b0, '0, 1'b0, "R9 run of ones");
            if (i >= 8) check(trig, 1'b1, "R9 held high");
        end
        wr(8'hFF, 1'b0, "R5 clear");

        // R8: entry 0 governs trig during and after clear
        wr(8'h00, 1'b1, "R8 program zero");
        step(1'b1, 1'b1, 1'b0, '0, 1'b0, "R8 in clear");
        check(trig, 1'b1, "R8 zero window fires");
        // R2: clear drops ser_in=1: window stays zero
        step(1'b1, 1'b1, 1'b0, '0, 1'b0, "R2 clear drops input");
        check(trig, 1'b1, "R2 window still zero");
        wr(8'h00, 1'b0, "R8 unprogram zero");
        step(1'b0, 1'b1, 1'b0, '0, 1'b0, "R8 zero window silent");
        check(trig, 1'b0, "R8 entry 0 clear gives low");

        // R7: write visible exactly one comparison later (window held at 0)
        step(1'b0, 1'b1, 1'b1, 8'h00, 1'b1, "R7 write edge");
        check(trig, 1'b0, "R7 old entry used on write edge");
        step(1'b0, 1'b1, 1'b0, '0, 1'b0, "R7 next edge");
        check(trig, 1'b1, "R7 new entry used next edge");
        wr(8'h00, 1'b0, "R7 cleanup");

        // Sweep: arithmetic table, every window value, then pseudo-random stream
        for (int i = 0; i < N; i++) wr(i[W-1:0], (((i * 37) + 11) % 5) == 0, "R7 sweep program");
        for (int v = 0; v < N; v++) feed_byte(v[7:0], "R1 R3 sweep all values");
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], (i % 97) == 0, (i % 13) == 0, lfsr[15:8], lfsr[3], "R2 R7 random stream");
        end
        wipe("R6 wipe");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule